// File: doc/BRIEF.md
# Edge-Triggered External Interrupt Unit

This unit watches three pins that double as general-purpose port bits and turns selected transitions on them into interrupt requests, one request line per pin. Software picks, per channel, whether rising edges, falling edges, both or neither count, and it arms or masks the request output. Each channel keeps a sticky flag that records a qualifying edge until software clears it.

A pin behaves as an interrupt source only while it is configured as an input. For channel 0 there is one further condition: the timer that shares that pin must not be driving it. Whatever the interrupt setup, software can always read the present level of every pin through the port data register. Pins pass through a two-flop synchronizer, and a matching edge sets its flag two to three clocks after the pin moves.

Register map (byte bus, 3-bit address): addresses 0, 1 and 2 hold the control bytes of channels 0, 1 and 2. In each control byte, bit 0 is the request enable, bits 2:1 are the edge select and bit 3 is the flag; the other bits read 0. Address 3 is the direction register. Address 4 is the port data register. Other addresses read 0.

Top module: `ext_edge_irq`

## Requirements
- R1: Channel i samples pin_in[i] and drives irq[i] alone. In the port byte, pin i sits at bit 4+i.
- R2: Edge select 2'b01 counts rising edges, 2'b10 counts falling edges and 2'b11 counts both. 2'b00 counts none, so the flag never sets.
- R3: The flag is sticky. Writing a control byte with bit 3 = 0 clears the flag. Writing bit 3 = 1 leaves the flag unchanged. A matching edge sets the flag at the second clock edge after the pin change is registered, which is visible three falling clock edges after the pin is driven.
- R4: If a matching edge and a clearing write fall in the same clock cycle, the flag ends up set.
- R5: irq[i] is high exactly when the flag, the enable bit and the channel's input condition are all true. With enable = 0 the flag still sets but irq stays low.
- R6: Direction register bit 4+i = 1 makes pin i an output. An output pin detects no edges, and its irq is forced low.
- R7: While timer_out_en = 1, channel 0 detects no edges and irq[0] stays low. Channels 1 and 2 are not affected.
- R8: Reading address 4 returns the synchronized pin levels on bits 6:4, whatever the direction, enable and edge settings. All other bits read 0, and writes to address 4 have no effect.
- R9: After reset, every control byte, the direction register and every irq output read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| pin_in | input | 3 | Pin levels, asynchronous |
| timer_out_en | input | 1 | Timer drives the channel 0 pin |
| irq | output | 3 | Interrupt request per channel |

## Verification
Two functions can land in the same cycle: a flag being set by a synchronized edge, and the same flag being cleared by a software write. The bench drives the pin, waits two falling edges and then raises a clearing write, so the clear and the edge detection coincide on one rising edge. It then reads the control byte back and expects bit 3 set. A second clear afterwards must drop the flag, which shows that the first clear was not simply lost.

// File: rtl/eei_pkg.sv
package eei_pkg;
  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_sel_e;

  // True when the transition prev->cur is one the selection counts.
  function automatic logic edge_match(edge_sel_e sel, logic prev, logic cur);
    logic rise, fall;
    rise = !prev && cur;
    fall = prev && !cur;
    case (sel)
      EDGE_RISE: edge_match = rise;
      EDGE_FALL: edge_match = fall;
      EDGE_BOTH: edge_match = rise || fall;
      default:   edge_match = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/eei_sync.sv
module eei_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/eei_channel.sv
module eei_channel
  import eei_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      level,       // synchronized pin level
  input  edge_sel_e sel,
  input  logic      input_mode,
  input  logic      clr,         // software clear request
  output logic      hit,         // qualifying edge this cycle
  output logic      flag
);
  logic prev;

  assign hit = input_mode && edge_match(sel, prev, level);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev <= 1'b0;
      flag <= 1'b0;
    end else begin
      prev <= level;
      if (hit)      flag <= 1'b1;   // set wins over clear
      else if (clr) flag <= 1'b0;
    end
  end
endmodule

// File: rtl/ext_edge_irq.sv
module ext_edge_irq
  import eei_pkg::*;
#(
  parameter int N_CH      = 3,
  parameter int AW        = 3,
  parameter int DW        = 8,
  parameter int PIN_LSB   = 4,
  parameter int SYNC_STGS = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [N_CH-1:0] pin_in,
  input  logic          timer_out_en,
  output logic [N_CH-1:0] irq
);
  localparam logic [AW-1:0] DIR_ADDR  = AW'(N_CH);
  localparam logic [AW-1:0] DATA_ADDR = AW'(N_CH + 1);
  localparam int EN_BIT   = 0;
  localparam int SEL_LSB  = 1;
  localparam int FLAG_BIT = 3;

  logic [N_CH-1:0] en_q, dir_q, level, input_mode, clr, hit, flag;
  edge_sel_e       sel_q [N_CH];

  logic unused_wdata;
  assign unused_wdata = ^bus_wdata;

  generate
    for (genvar i = 0; i < N_CH; i++) begin : g_ch
      eei_sync #(.STAGES(SYNC_STGS)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pin_in[i]), .q(level[i])
      );

      if (i == 0) begin : g_timer_gate
        assign input_mode[i] = !dir_q[i] && !timer_out_en;
      end else begin : g_plain
        assign input_mode[i] = !dir_q[i];
      end

      assign clr[i] = bus_wr && (bus_addr == AW'(i)) && !bus_wdata[FLAG_BIT];

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          en_q[i]  <= 1'b0;
          sel_q[i] <= EDGE_OFF;
        end else if (bus_wr && bus_addr == AW'(i)) begin
          en_q[i]  <= bus_wdata[EN_BIT];
          sel_q[i] <= edge_sel_e'(bus_wdata[SEL_LSB +: 2]);
        end
      end

      eei_channel u_chan (
        .clk(clk), .rst_n(rst_n), .level(level[i]), .sel(sel_q[i]),
        .input_mode(input_mode[i]), .clr(clr[i]), .hit(hit[i]), .flag(flag[i])
      );

      assign irq[i] = flag[i] && en_q[i] && input_mode[i];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             dir_q <= '0;
    else if (bus_wr && bus_addr == DIR_ADDR) dir_q <= bus_wdata[PIN_LSB +: N_CH];
  end

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < N_CH; i++) begin
      if (bus_addr == AW'(i)) begin
        bus_rdata[EN_BIT]          = en_q[i];
        bus_rdata[SEL_LSB +: 2]    = sel_q[i];
        bus_rdata[FLAG_BIT]        = flag[i];
      end
    end
    if (bus_addr == DIR_ADDR)  bus_rdata[PIN_LSB +: N_CH] = dir_q;
    if (bus_addr == DATA_ADDR) bus_rdata[PIN_LSB +: N_CH] = level;
  end
endmodule

// File: rtl/eei_checker.sv
module eei_checker #(
  parameter int N_CH = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic [N_CH-1:0] irq,
  input logic [N_CH-1:0] flag,
  input logic [N_CH-1:0] hit,
  input logic [N_CH-1:0] clr,
  input logic [N_CH-1:0] input_mode,
  input logic            timer_out_en
);
  generate
    for (genvar i = 0; i < N_CH; i++) begin : g_chk
      // R3: a flag only rises after a qualifying edge
      assert_flag_rise_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag[i]) |-> $past(hit[i]));
      // R3: a flag only falls after a clear with no competing edge
      assert_flag_fall_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag[i]) |-> ($past(clr[i]) && !$past(hit[i])));
      // R4: an edge always leaves the flag set, clear or not
      assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        hit[i] |=> flag[i]);
      // R5: a request needs a stored flag
      assert_irq_needs_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq[i] |-> flag[i]);
      // R6: no edge is detected on a pin that is not an input
      assert_no_hit_output_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !input_mode[i] |-> !hit[i]);
    end
  endgenerate

  // R7: timer output on the channel 0 pin blocks its request
  assert_timer_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    timer_out_en |-> (!irq[0] && !hit[0]));
endmodule

bind ext_edge_irq eei_checker #(.N_CH(N_CH)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq), .flag(flag), .hit(hit),
  .clr(clr), .input_mode(input_mode), .timer_out_en(timer_out_en)
);

// File: tb/ext_edge_irq_tb.sv
module ext_edge_irq_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [2:0] pin_in = '0;
  logic       timer_out_en = 1'b0;
  logic [2:0] irq;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ext_edge_irq u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .timer_out_en(timer_out_en), .irq(irq)
  );

  // control byte: bit0 enable, bits2:1 edge select, bit3 flag
  function automatic logic [7:0] ctl(logic en, logic [1:0] sel, logic keep_flag);
    return {4'b0, keep_flag, sel, en};
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    for (int a = 0; a < 4; a++) begin
      rd(3'(a), d);
      check("R9 reset reg", d, 8'h00);
    end
    check("R9 reset irq", {5'b0, irq}, 8'h00);
  endtask

  task automatic t_rise();
    logic [7:0] d;
    wr(3'd1, ctl(1, 2'b01, 1));
    pin_in[1] = 1'b1; settle();
    check("R1 R2 rise irq only ch1", {5'b0, irq}, 8'h02);
    rd(3'd1, d); check("R3 flag set", d, 8'h0B);
    pin_in[1] = 1'b0; settle();
    wr(3'd1, ctl(1, 2'b01, 1));
    rd(3'd1, d); check("R3 write 1 keeps flag", d, 8'h0B);
    wr(3'd1, ctl(1, 2'b01, 0));
    rd(3'd1, d); check("R3 write 0 clears", d, 8'h03);
    check("R3 irq drops", {5'b0, irq}, 8'h00);
    pin_in[1] = 1'b1; @(negedge clk); @(negedge clk);
    rd(3'd1, d); check("R3 not yet set before third edge", d, 8'h03);
    @(negedge clk);
    rd(3'd1, d); check("R3 set on third falling edge", d, 8'h0B);
    pin_in[1] = 1'b0; settle();
    wr(3'd1, ctl(0, 2'b00, 0));
  endtask

  task automatic t_fall();
    logic [7:0] d;
    wr(3'd2, ctl(1, 2'b10, 0));
    pin_in[2] = 1'b1; settle();
    rd(3'd2, d); check("R2 fall ignores rise", d, 8'h05);
    pin_in[2] = 1'b0; settle();
    rd(3'd2, d); check("R2 fall sets", d, 8'h0D);
    check("R1 irq ch2", {5'b0, irq}, 8'h04);
    wr(3'd2, ctl(0, 2'b00, 0));
  endtask

  task automatic t_both();
    logic [7:0] d;
    wr(3'd0, ctl(1, 2'b11, 0));
    pin_in[0] = 1'b1; settle();
    rd(3'd0, d); check("R2 both rise", d, 8'h0F);
    wr(3'd0, ctl(1, 2'b11, 0));
    pin_in[0] = 1'b0; settle();
    rd(3'd0, d); check("R2 both fall", d, 8'h0F);
    check("R1 irq ch0", {5'b0, irq}, 8'h01);
    wr(3'd0, ctl(0, 2'b00, 0));
  endtask

  task automatic t_off();
    logic [7:0] d;
    wr(3'd0, ctl(1, 2'b00, 0));
    pin_in[0] = 1'b1; settle();
    pin_in[0] = 1'b0; settle();
    rd(3'd0, d); check("R2 off no flag", d, 8'h01);
    check("R2 off no irq", {5'b0, irq}, 8'h00);
  endtask

  task automatic t_mask();
    logic [7:0] d;
    wr(3'd1, ctl(0, 2'b01, 0));
    pin_in[1] = 1'b1; settle();
    check("R5 masked irq", {5'b0, irq}, 8'h00);
    rd(3'd1, d); check("R5 flag still sets", d, 8'h0A);
    wr(3'd1, ctl(1, 2'b01, 1));
    check("R5 enable releases irq", {5'b0, irq}, 8'h02);
    pin_in[1] = 1'b0; settle();
    wr(3'd1, ctl(0, 2'b00, 0));
  endtask

  task automatic t_dir();
    logic [7:0] d;
    wr(3'd3, 8'h40);
    rd(3'd3, d); check("R6 dir readback", d, 8'h40);
    wr(3'd2, ctl(1, 2'b11, 0));
    pin_in[2] = 1'b1; settle();
    rd(3'd2, d); check("R6 output pin no flag", d, 8'h07);
    wr(3'd3, 8'h00);
    pin_in[2] = 1'b0; settle();
    check("R6 input again irq", {5'b0, irq}, 8'h04);
    wr(3'd3, 8'h40);
    check("R6 output forces irq low", {5'b0, irq}, 8'h00);
    wr(3'd3, 8'h00);
    wr(3'd2, ctl(0, 2'b00, 0));
  endtask

  task automatic t_timer();
    logic [7:0] d;
    wr(3'd0, ctl(1, 2'b01, 0));
    wr(3'd1, ctl(1, 2'b01, 0));
    timer_out_en = 1'b1;
    pin_in[0] = 1'b1; pin_in[1] = 1'b1; settle();
    rd(3'd0, d); check("R7 timer blocks ch0", d, 8'h03);
    check("R7 ch1 unaffected", {5'b0, irq}, 8'h02);
    timer_out_en = 1'b0;
    pin_in[0] = 1'b0; settle();
    pin_in[0] = 1'b1; settle();
    check("R7 ch0 live without timer", {5'b0, irq}, 8'h03);
    timer_out_en = 1'b1; #1;
    check("R7 timer masks irq0", {5'b0, irq}, 8'h02);
    timer_out_en = 1'b0;
    wr(3'd0, ctl(0, 2'b00, 0));
    wr(3'd1, ctl(0, 2'b00, 0));
    pin_in = 3'b000; settle();
  endtask

  task automatic t_port();
    logic [7:0] d;
    wr(3'd3, 8'h20);
    pin_in = 3'b101; settle();
    rd(3'd4, d); check("R8 levels 101", d, 8'h50);
    wr(3'd4, 8'hFF);
    pin_in = 3'b010; settle();
    rd(3'd4, d); check("R8 levels 010 write ignored", d, 8'h20);
    wr(3'd3, 8'h00);
    pin_in = 3'b000; settle();
  endtask

  task automatic t_race();
    logic [7:0] d;
    wr(3'd2, ctl(1, 2'b01, 0));
    pin_in[2] = 1'b1;
    @(negedge clk); @(negedge clk);
    wr(3'd2, ctl(1, 2'b01, 0));  // clear lands with the edge
    rd(3'd2, d); check("R4 set wins", d, 8'h0B);
    wr(3'd2, ctl(1, 2'b01, 0));
    rd(3'd2, d); check("R4 later clear works", d, 8'h03);
    pin_in[2] = 1'b0; settle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_rise();
    t_fall();
    t_both();
    t_off();
    t_mask();
    t_dir();
    t_timer();
    t_port();
    t_race();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule